// File: doc/BRIEF.md
# SPI Master Select and Transfer Timing Sequencer

This block paces each transfer of an SPI master. When the unit is enabled and a start request is seen, it asserts one of several slave-select lines and waits a programmable lead time. It then gives a one-cycle start pulse to a separate shift engine, and while the shift runs it supplies half-bit-period ticks. After the engine reports the last bit, it waits a programmable trail time and then negates the select, unless the hold option is set. A programmable gap follows, then a one-cycle done pulse. All three delays are counted in whole bit periods. The bit period comes from a rate value and a power-of-two divide code.

Each select line has its own polarity bit. The block also drives the idle level of the serial clock and a busy flag that covers the whole sequence, delays included. The select index and the clock polarity are captured when a transfer starts. The rate, divide code and delay settings are expected to stay stable while a transfer runs.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset, busy, done and shiftStart are 0, and every select output sits at its negated level. The negated level is the inverse of that line's polarity bit.
- R2: A transfer begins only on a clock where enable and startReq are both 1. With enable at 0, a startReq is ignored: busy stays 0 and the selects stay negated.
- R3: From the start of the lead phase to the end of the trail phase, exactly one select line is asserted: the line numbered by selIdx (0..3). A polarity bit of 0 makes that line active low, and 1 makes it active high. All other lines stay negated.
- R4: shiftStart is high for exactly one cycle. It rises lead × P cycles after the select asserts, where lead is leadVal+1 when leadEn is 1 and 1 otherwise.
- R5: The bit period is P = 2 × (rateVal+1) × 2^divCode system clocks, with divCode 0..3 giving ×1, ×2, ×4 or ×8. While the shift runs, halfTick pulses every P/2 clocks. The first pulse comes P/2−1 clocks after the shiftStart cycle.
- R6: When engineDone is taken on a clock edge, the select negates trail × P clocks later. trail is trailVal+1 when trailEn is 1 and 1 otherwise.
- R7: done pulses for one cycle gap × P + 2 clocks after the select negates. gap is gapVal+1 when gapEn is 1 and 1 otherwise. On the same clock edge, the block returns to idle.
- R8: With keepSel at 1, the selected line stays asserted after done, through idle, until the next transfer starts. At that start the select moves to the newly chosen line.
- R9: busy is 1 from the cycle the select asserts until the cycle done pulses, in which busy is 0.
- R10: When idle, sckIdle equals clkPol (0 = clock low at idle). From lead through trail, sckIdle holds the clkPol value captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Unit enable |
| startReq | input | 1 | Request to begin a transfer |
| engineDone | input | 1 | Shift engine reports last bit done |
| rateVal | input | 8 | Base bit-rate value |
| divCode | input | 2 | Extra divide: 1, 2, 4 or 8 |
| selIdx | input | 2 | Select line to assert |
| selPol | input | 4 | Per-line polarity, 1 = active high |
| keepSel | input | 1 | Hold select asserted between accesses |
| clkPol | input | 1 | Serial clock idle level |
| leadEn | input | 1 | Use leadVal for select-to-clock delay |
| leadVal | input | 3 | Lead delay minus one, in periods |
| trailEn | input | 1 | Use trailVal for clock-to-negate delay |
| trailVal | input | 3 | Trail delay minus one, in periods |
| gapEn | input | 1 | Use gapVal for next-access gap |
| gapVal | input | 3 | Gap minus one, in periods |
| selOut | output | 4 | Slave-select lines |
| sckIdle | output | 1 | Serial clock idle level |
| shiftStart | output | 1 | One-cycle start pulse to shift engine |
| halfTick | output | 1 | Half-bit-period tick during shift |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with its default parameters: four select lines, an 8-bit rate value and 3-bit delay fields. It sweeps rate values 0 to 2 across all four divide codes, once with every delay at its default and once with programmed delay values that change from run to run. Because these periods stay short, every lead, trail and gap length, each tick spacing and every select line and polarity pattern can be measured in cycles against the arithmetic of the requirements. Separate runs cover the ignored start while disabled, a held select that moves to another line, and a clock polarity change in the middle of a transfer.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_KICK,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } seq_state_t;

  typedef struct packed {
    logic loadLead;
    logic loadTrail;
    logic loadGap;
    logic countEn;
    logic latchCfg;
    logic selOn;
    logic holdSet;
    logic tickRun;
  } seq_strobe_t;

endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        startReq,
  input  logic        engineDone,
  input  logic        cntLast,
  output seq_strobe_t strobe,
  output logic        shiftStart,
  output logic        busy,
  output logic        done
);

  seq_state_t state;
  seq_state_t nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (enable && startReq) begin
          nextState       = ST_LEAD;
          strobe.loadLead = 1'b1;
          strobe.latchCfg = 1'b1;
        end
      end
      ST_LEAD: begin
        strobe.countEn = 1'b1;
        strobe.selOn   = 1'b1;
        if (cntLast) nextState = ST_KICK;
      end
      ST_KICK: begin
        strobe.selOn   = 1'b1;
        strobe.tickRun = 1'b1;
        nextState      = ST_SHIFT;
      end
      ST_SHIFT: begin
        strobe.selOn   = 1'b1;
        strobe.tickRun = 1'b1;
        if (engineDone) begin
          nextState        = ST_TRAIL;
          strobe.loadTrail = 1'b1;
        end
      end
      ST_TRAIL: begin
        strobe.selOn   = 1'b1;
        strobe.countEn = 1'b1;
        if (cntLast) begin
          nextState      = ST_GAP;
          strobe.loadGap = 1'b1;
          strobe.holdSet = 1'b1;
        end
      end
      ST_GAP: begin
        strobe.countEn = 1'b1;
        if (cntLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == ST_GAP) && cntLast;
    end
  end

  assign shiftStart = (state == ST_KICK);
  assign busy       = (state != ST_IDLE);

  // R4: start pulse lasts one cycle only
  p_kick_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    shiftStart |=> !shiftStart);

  // R7: done is a single-cycle pulse that follows the gap phase
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(state == ST_GAP));

  // R2: busy rises only after an enabled start request
  p_start_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enable && startReq));

endmodule

// File: rtl/spi_seq_datapath.sv
module spi_seq_datapath
  import spi_seq_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int RATE_W  = 8,
  parameter int DLY_W   = 3,
  parameter int DIV_W   = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seq_strobe_t                strobe,
  input  logic [RATE_W-1:0]          rateVal,
  input  logic [DIV_W-1:0]           divCode,
  input  logic [$clog2(NUM_SEL)-1:0] selIdx,
  input  logic [NUM_SEL-1:0]         selPol,
  input  logic                       keepSel,
  input  logic                       clkPol,
  input  logic                       leadEn,
  input  logic [DLY_W-1:0]           leadVal,
  input  logic                       trailEn,
  input  logic [DLY_W-1:0]           trailVal,
  input  logic                       gapEn,
  input  logic [DLY_W-1:0]           gapVal,
  output logic                       cntLast,
  output logic [NUM_SEL-1:0]         selOut,
  output logic                       sckIdle,
  output logic                       halfTick
);

  localparam int SEL_IDX_W = $clog2(NUM_SEL);
  localparam int DIV_MAX   = (1 << DIV_W) - 1;
  localparam int PERIOD_W  = RATE_W + 2 + DIV_MAX;
  localparam int CNT_W     = PERIOD_W + DLY_W + 2;
  localparam int MULT_W    = DLY_W + 1;

  logic [PERIOD_W-1:0]  halfCycles;
  logic [PERIOD_W-1:0]  periodCycles;
  logic [MULT_W-1:0]    leadMul, trailMul, gapMul;
  logic [CNT_W-1:0]     leadCycles, trailCycles, gapCycles;
  logic [CNT_W-1:0]     dlyCnt;
  logic [PERIOD_W-1:0]  tickCnt;
  logic [SEL_IDX_W-1:0] activeIdx;
  logic                 polLatched;
  logic                 selHeld;
  logic [NUM_SEL-1:0]   actMask;

  // bit period arithmetic
  assign halfCycles   = PERIOD_W'({1'b0, rateVal} + 1'b1) << divCode;
  assign periodCycles = halfCycles << 1;

  assign leadMul  = leadEn  ? MULT_W'({1'b0, leadVal}  + 1'b1) : MULT_W'(1);
  assign trailMul = trailEn ? MULT_W'({1'b0, trailVal} + 1'b1) : MULT_W'(1);
  assign gapMul   = gapEn   ? MULT_W'({1'b0, gapVal}   + 1'b1) : MULT_W'(1);

  assign leadCycles  = CNT_W'(leadMul)  * CNT_W'(periodCycles);
  assign trailCycles = CNT_W'(trailMul) * CNT_W'(periodCycles);
  assign gapCycles   = CNT_W'(gapMul)   * CNT_W'(periodCycles) + CNT_W'(2);

  // phase delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (strobe.loadLead) begin
      dlyCnt <= leadCycles;
    end else if (strobe.loadTrail) begin
      dlyCnt <= trailCycles;
    end else if (strobe.loadGap) begin
      dlyCnt <= gapCycles;
    end else if (strobe.countEn && (dlyCnt != '0)) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign cntLast = (dlyCnt == CNT_W'(1));

  // half-period tick generator during the shift phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (!strobe.tickRun) begin
      tickCnt <= '0;
    end else if (tickCnt == halfCycles - 1'b1) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign halfTick = strobe.tickRun && (tickCnt == halfCycles - 1'b1);

  // captured per-transfer settings and the hold flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeIdx  <= '0;
      polLatched <= 1'b0;
      selHeld    <= 1'b0;
    end else begin
      if (strobe.latchCfg) begin
        activeIdx  <= selIdx;
        polLatched <= clkPol;
        selHeld    <= 1'b0;
      end else if (strobe.holdSet) begin
        selHeld    <= keepSel;
      end
    end
  end

  assign actMask = (strobe.selOn || selHeld) ? (NUM_SEL'(1) << activeIdx) : '0;

  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_sel
    assign selOut[gi] = actMask[gi] ? selPol[gi] : ~selPol[gi];
  end

  assign sckIdle = strobe.selOn ? polLatched : clkPol;

  // R3: at most one select line at its asserted level
  p_one_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOut ~^ selPol));

  // R6: the delay counter never runs dry while a timed phase is active
  p_count_live_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countEn |-> (dlyCnt != '0));

  // R5: ticks are separated by at least the half period
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
    (halfTick && halfCycles > 1) |=> !halfTick);

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer #(
  parameter int NUM_SEL = 4,
  parameter int RATE_W  = 8,
  parameter int DLY_W   = 3,
  parameter int DIV_W   = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       startReq,
  input  logic                       engineDone,
  input  logic [RATE_W-1:0]          rateVal,
  input  logic [DIV_W-1:0]           divCode,
  input  logic [$clog2(NUM_SEL)-1:0] selIdx,
  input  logic [NUM_SEL-1:0]         selPol,
  input  logic                       keepSel,
  input  logic                       clkPol,
  input  logic                       leadEn,
  input  logic [DLY_W-1:0]           leadVal,
  input  logic                       trailEn,
  input  logic [DLY_W-1:0]           trailVal,
  input  logic                       gapEn,
  input  logic [DLY_W-1:0]           gapVal,
  output logic [NUM_SEL-1:0]         selOut,
  output logic                       sckIdle,
  output logic                       shiftStart,
  output logic                       halfTick,
  output logic                       busy,
  output logic                       done
);

  import spi_seq_pkg::*;

  seq_strobe_t strobe;
  logic        cntLast;

  spi_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .startReq   (startReq),
    .engineDone (engineDone),
    .cntLast    (cntLast),
    .strobe     (strobe),
    .shiftStart (shiftStart),
    .busy       (busy),
    .done       (done)
  );

  spi_seq_datapath #(
    .NUM_SEL (NUM_SEL),
    .RATE_W  (RATE_W),
    .DLY_W   (DLY_W),
    .DIV_W   (DIV_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rateVal  (rateVal),
    .divCode  (divCode),
    .selIdx   (selIdx),
    .selPol   (selPol),
    .keepSel  (keepSel),
    .clkPol   (clkPol),
    .leadEn   (leadEn),
    .leadVal  (leadVal),
    .trailEn  (trailEn),
    .trailVal (trailVal),
    .gapEn    (gapEn),
    .gapVal   (gapVal),
    .cntLast  (cntLast),
    .selOut   (selOut),
    .sckIdle  (sckIdle),
    .halfTick (halfTick)
  );

endmodule

// File: tb/spi_cs_sequencer_bench.sv
module spi_cs_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0, startReq = 1'b0, engineDone = 1'b0;
  logic [7:0] rateVal = '0;
  logic [1:0] divCode = '0;
  logic [1:0] selIdx = '0;
  logic [3:0] selPol = 4'b0000;
  logic       keepSel = 1'b0, clkPol = 1'b0;
  logic       leadEn = 1'b0, trailEn = 1'b0, gapEn = 1'b0;
  logic [2:0] leadVal = '0, trailVal = '0, gapVal = '0;
  logic [3:0] selOut;
  logic       sckIdle, shiftStart, halfTick, busy, done;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_cs_sequencer u_spi_cs_sequencer (
    .clk(clk), .rstN(rstN), .enable(enable), .startReq(startReq),
    .engineDone(engineDone), .rateVal(rateVal), .divCode(divCode),
    .selIdx(selIdx), .selPol(selPol), .keepSel(keepSel), .clkPol(clkPol),
    .leadEn(leadEn), .leadVal(leadVal), .trailEn(trailEn), .trailVal(trailVal),
    .gapEn(gapEn), .gapVal(gapVal), .selOut(selOut), .sckIdle(sckIdle),
    .shiftStart(shiftStart), .halfTick(halfTick), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] expSel(input int idx, input bit on);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = (on && i == idx) ? selPol[i] : ~selPol[i];
    return v;
  endfunction

  // one full transfer; timing measured at negedges against the cycle counter
  task automatic run_xfer(input int idx, input bit keep, input bit polFlip);
    int h, p, ln, tn, gn, aCnt, kCnt, eCnt, negCnt, lastT, ticks, guard;
    bit origPol;
    h  = (int'(rateVal) + 1) << divCode;
    p  = 2 * h;
    ln = leadEn  ? int'(leadVal)  + 1 : 1;
    tn = trailEn ? int'(trailVal) + 1 : 1;
    gn = gapEn   ? int'(gapVal)   + 1 : 1;
    selIdx   = 2'(idx);
    keepSel  = keep;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    aCnt = cyc;
    check(busy == 1'b1, "R9 busy at start", busy, 1);
    check(selOut == expSel(idx, 1'b1), "R3 select asserted", selOut, expSel(idx, 1'b1));
    origPol = clkPol;
    if (polFlip) begin
      check(sckIdle == origPol, "R10 captured idle level", sckIdle, origPol);
      clkPol = ~clkPol;
    end
    guard = 0;
    while (!shiftStart && guard < GUARD) begin @(negedge clk); guard++; end
    kCnt = cyc;
    check(kCnt - aCnt == ln * p, "R4 lead delay", kCnt - aCnt, ln * p);
    if (polFlip) check(sckIdle == origPol, "R10 idle level held", sckIdle, origPol);
    ticks = 0; lastT = 0; guard = 0;
    while (ticks < 2 && guard < GUARD) begin
      if (halfTick) begin
        if (ticks == 0) check(cyc - kCnt == h - 1, "R5 first tick", cyc - kCnt, h - 1);
        else            check(cyc - lastT == h, "R5 tick spacing", cyc - lastT, h);
        lastT = cyc;
        ticks++;
      end
      if (ticks < 2) begin
        @(negedge clk); guard++;
        if (cyc == kCnt + 1) check(shiftStart == 1'b0, "R4 start pulse width", shiftStart, 0);
      end
    end
    engineDone = 1'b1;
    eCnt = cyc;
    @(negedge clk);
    engineDone = 1'b0;
    negCnt = -1; guard = 0;
    while (!done && guard < GUARD) begin
      if (!keep && negCnt < 0 && selOut == expSel(idx, 1'b0)) negCnt = cyc;
      @(negedge clk); guard++;
    end
    check(cyc - eCnt == tn * p + gn * p + 2 + 1, "R7 gap to done", cyc - eCnt, tn * p + gn * p + 3);
    check(busy == 1'b0, "R9 busy low with done", busy, 0);
    if (!keep) begin
      check(negCnt - eCnt == tn * p + 1, "R6 trail delay", negCnt - eCnt, tn * p + 1);
      check(cyc - negCnt == gn * p + 2, "R7 gap length", cyc - negCnt, gn * p + 2);
    end
    @(negedge clk);
    check(done == 1'b0, "R7 done pulse width", done, 0);
    if (keep) check(selOut == expSel(idx, 1'b1), "R8 select held", selOut, expSel(idx, 1'b1));
    else      check(selOut == expSel(idx, 1'b0), "R3 select negated", selOut, expSel(idx, 1'b0));
    if (polFlip) begin
      check(sckIdle == clkPol, "R10 idle follows input", sckIdle, clkPol);
      clkPol = origPol;
    end
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    selPol = 4'b0101;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset status", {busy, done}, 0);
    check(shiftStart == 1'b0, "R1 reset start", shiftStart, 0);
    check(selOut == 4'b1010, "R1 reset selects", selOut, 4'b1010);
    rstN = 1'b1;
    @(negedge clk);
    check(sckIdle == clkPol, "R10 idle level", sckIdle, clkPol);

    // R2: start request while disabled
    startReq = 1'b1;
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R2 no start when disabled", busy, 0);
    check(selOut == 4'b1010, "R2 selects untouched", selOut, 4'b1010);
    startReq = 1'b0;
    enable = 1'b1;
    @(negedge clk);

    // sweep over rate, divide and delay modes
    for (int r = 0; r < 3; r++) begin
      for (int d = 0; d < 4; d++) begin
        for (int m = 0; m < 2; m++) begin
          rateVal  = 8'(r);
          divCode  = 2'(d);
          selPol   = 4'((r * 5 + d * 3 + m) & 15);
          leadEn   = m[0]; leadVal  = 3'((r + d) % 8);
          trailEn  = m[0]; trailVal = 3'((r + 2 * d + 1) % 8);
          gapEn    = m[0]; gapVal   = 3'((3 * r + d + 2) % 8);
          @(negedge clk);
          run_xfer((r + d + m) % 4, 1'b0, (d == 1));
        end
      end
    end

    // R8: hold select, then move to another line
    rateVal = 8'd1; divCode = 2'd0; selPol = 4'b0110;
    leadEn = 1'b0; trailEn = 1'b1; trailVal = 3'd2; gapEn = 1'b0;
    run_xfer(2, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(selOut == expSel(2, 1'b1), "R8 held through idle", selOut, expSel(2, 1'b1));
    check(busy == 1'b0, "R8 idle while held", busy, 0);
    run_xfer(1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule